// File: doc/BRIEF.md
# Memory Instruction Issue Stage

This block is the per-cycle issue front end of a trace-driven core model. It holds one trace record: a count of non-memory instructions followed by one memory read to a block address. Each clock it walks up to `IPC` window slots, lowest slot first. The pending non-memory instructions go out first, each as a ready, non-memory window entry. When the count reaches zero, the record's read takes one memory step. That step can be a false miss (the block is already tracked in the window), an L1 hit, an MSHR reservation, an L2 hit sent to the hit-delay queue, or a dispatch to the memory controller.

The window, the caches, the MSHR storage, the hit queue and the trace reader are all external. The stage drives the record's address out on `look_addr`. The external units answer in the same cycle with the lookup and accept inputs. The trace reader presents the next record on `rec_*` and sees `rec_pop` when the stage loads it. Only one record is looked at per cycle, so a memory step always ends the slot walk for that cycle. If the MSHR or the controller refuses, a sticky retry flag holds the record. The flag blocks every slot until the matching accept input is seen on a later cycle, and the read is tried again on the cycle after that.

Top module: `issue_stage`

## Requirements
- R1: After reset no window entry is added, `mshr_req`, `mem_req` and `hitq_push` are low, both retry flags are low, `stall_cnt` is 0, and no record is held, so `rec_pop` equals `rec_valid`.
- R2: Slot i (0 to IPC-1) may be used only when `win_free` > i. While the held count is nonzero, each usable slot adds an entry with `add_rdy`=1 and `add_mem`=0 and lowers the count by one. Used slots always form a contiguous run starting at bit 0 of `add_vld`.
- R3: `stall_cnt` rises by exactly one on every clock edge where `win_free` was 0, and it holds otherwise.
- R4: On the memory step with `win_dup`=1, the read is dropped as a false miss. No entry is added, `mshr_req` and `mem_req` stay low, and the record is consumed.
- R5: On the memory step with `win_dup`=0 and `l1_hit`=1, one entry is added with `add_rdy`=1 and `add_mem`=1, `add_addr` shows the block address, no MSHR or controller request is made, and the record is consumed.
- R6: On an L1 miss, `mshr_req` is raised. If `mshr_ok`=0, no entry is added and `mshr_retry` is high after the edge.
- R7: On an L1 miss with the MSHR accepted and `l2_hit`=1, `hitq_push` is raised for one cycle, no window entry is added, and the record is consumed.
- R8: On an L2 miss with `ctrl_ok`=1, `mem_req` is raised and one entry is added with `add_rdy`=0 and `add_mem`=1.
- R9: On an L2 miss with `ctrl_ok`=0, no entry is added, `mem_req` stays low, and `ctrl_retry` is high after the edge.
- R10: At most one memory step is taken per cycle, and no slot after it adds an entry in that cycle.
- R11: While either retry flag is high, no slot is used and no request is raised. A flag clears on the first later cycle whose matching accept (`mshr_ok` or `ctrl_ok`) is high.
- R12: When no record is held, or the held record is consumed, and `rec_valid`=1, `rec_pop` is high and the record loads at that edge. Its count is issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Trace reader offers a record |
| rec_gap | input | GAP_W | Non-memory instructions ahead of the read |
| rec_addr | input | ADDR_W | Block address of the read |
| rec_pop | output | 1 | Record taken this cycle |
| look_addr | output | ADDR_W | Block address under lookup |
| win_free | input | $clog2(IPC+1) | Free window slots this cycle |
| win_dup | input | 1 | Block already tracked in the window |
| l1_hit | input | 1 | L1 holds the block |
| mshr_ok | input | 1 | MSHR accepts a reservation |
| l2_hit | input | 1 | L2 holds the block |
| ctrl_ok | input | 1 | Memory controller accepts the read |
| add_vld | output | IPC | Window add strobe per slot |
| add_rdy | output | IPC | Entry is ready at add |
| add_mem | output | IPC | Entry is a memory read |
| add_addr | output | ADDR_W | Block address for memory entries |
| mshr_req | output | 1 | MSHR reservation attempt |
| mem_req | output | 1 | Read dispatched to the controller |
| hitq_push | output | 1 | Read sent to the L2 hit-delay queue |
| mshr_retry | output | 1 | Sticky MSHR refusal flag |
| ctrl_retry | output | 1 | Sticky controller refusal flag |
| stall_cnt | output | STALL_W | Cycles that began with a full window |

## Verification
The non-memory drain of a record and the memory step of the same record often fall in one cycle. This happens whenever the held count is smaller than the number of free slots. The bench provokes it by sweeping every count from 0 to 5 against every free-slot value from 0 to 4, for each of the six memory outcomes. For each cycle it computes the exact `add_vld`, `add_rdy` and `add_mem` masks from the count and the free slots. Each mask must show the ready non-memory run, then at most one memory entry directly above it, and nothing above that.

// File: rtl/issue_pkg.sv
package issue_pkg;

  // Same-cycle answers from the external window, caches, MSHR and controller
  typedef struct packed {
    logic dup;
    logic l1;
    logic mshr_ok;
    logic l2;
    logic ctrl_ok;
  } lookup_t;

  // What one slot did with the memory read
  typedef struct packed {
    logic consume;
    logic mshr_try;
    logic mshr_fail;
    logic ctrl_fail;
    logic issue;
    logic hitq;
  } step_t;

endpackage

// File: rtl/issue_slot.sv
module issue_slot
  import issue_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             run_in,
  input  logic             slot_free,
  input  logic [GAP_W-1:0] gap_in,
  input  lookup_t          lk,
  output logic             run_out,
  output logic [GAP_W-1:0] gap_out,
  output logic             add_v,
  output logic             add_r,
  output logic             add_m,
  output logic             mem_step,
  output step_t            step
);

  logic act;
  logic nonmem;
  logic l1_take;
  logic miss_try;
  logic l2_take;
  logic ctrl_try;

  always_comb begin
    act      = run_in & slot_free;
    nonmem   = act & (gap_in != '0);
    mem_step = act & (gap_in == '0);
    l1_take  = mem_step & ~lk.dup & lk.l1;
    miss_try = mem_step & ~lk.dup & ~lk.l1;
    l2_take  = miss_try & lk.mshr_ok & lk.l2;
    ctrl_try = miss_try & lk.mshr_ok & ~lk.l2;

    step.mshr_try  = miss_try;
    step.mshr_fail = miss_try & ~lk.mshr_ok;
    step.hitq      = l2_take;
    step.issue     = ctrl_try & lk.ctrl_ok;
    step.ctrl_fail = ctrl_try & ~lk.ctrl_ok;
    step.consume   = (mem_step & lk.dup) | l1_take | l2_take | step.issue;

    add_v   = nonmem | l1_take | step.issue;
    add_r   = nonmem | l1_take;
    add_m   = l1_take | step.issue;
    run_out = nonmem;
    gap_out = nonmem ? gap_in - 1'b1 : gap_in;
  end

endmodule

// File: rtl/issue_state.sv
module issue_state #(
  parameter int GAP_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              mshr_fail,
  input  logic              ctrl_fail,
  input  logic              mshr_ok,
  input  logic              ctrl_ok,
  input  logic [GAP_W-1:0]  gap_after,
  input  logic              rec_valid,
  input  logic [GAP_W-1:0]  rec_gap,
  input  logic [ADDR_W-1:0] rec_addr,
  output logic              rec_pop,
  output logic              cur_valid,
  output logic [GAP_W-1:0]  cur_gap,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mshr_retry,
  output logic              ctrl_retry
);

  logic              take;
  logic              valid_n;
  logic [GAP_W-1:0]  gap_n;
  logic [ADDR_W-1:0] addr_n;
  logic              mretry_n;
  logic              cretry_n;
  logic              rec_en;

  always_comb begin
    take     = (consume | ~cur_valid) & rec_valid;
    rec_pop  = take;
    valid_n  = take | (cur_valid & ~consume);
    gap_n    = take ? rec_gap : gap_after;
    addr_n   = take ? rec_addr : cur_addr;
    rec_en   = take | cur_valid;
    mretry_n = mshr_retry ? ~mshr_ok : mshr_fail;
    cretry_n = ctrl_retry ? ~ctrl_ok : ctrl_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid  <= 1'b0;
      cur_gap    <= '0;
      cur_addr   <= '0;
      mshr_retry <= 1'b0;
      ctrl_retry <= 1'b0;
    end else begin
      cur_valid  <= valid_n;
      mshr_retry <= mretry_n;
      ctrl_retry <= cretry_n;
      if (rec_en) begin
        cur_gap  <= gap_n;
        cur_addr <= addr_n;
      end
    end
  end

  // R6: a refused reservation leaves the flag raised
  a_r6_mshr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mshr_fail |=> mshr_retry);

  // R11: a raised flag stays up until its accept is seen
  a_r11_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_retry && !ctrl_ok) |=> ctrl_retry);

  // R12: a loaded record becomes the held one
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pop |=> (cur_valid && cur_addr == $past(rec_addr)));

endmodule

// File: rtl/issue_stall_ctr.sv
module issue_stall_ctr #(
  parameter int STALL_W = 16,
  parameter int FREE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FREE_W-1:0]  win_free,
  output logic [STALL_W-1:0] stall_cnt
);

  logic               inc_en;
  logic [STALL_W-1:0] cnt_n;

  always_comb begin
    inc_en = (win_free == '0);
    cnt_n  = stall_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
    end else if (inc_en) begin
      stall_cnt <= cnt_n;
    end
  end

  a_r3_stall_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (win_free == '0) |=> (stall_cnt == $past(stall_cnt) + 1'b1));

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_free != '0) |=> $stable(stall_cnt));

endmodule

// File: rtl/issue_stage.sv
module issue_stage
  import issue_pkg::*;
#(
  parameter int IPC     = 4,
  parameter int GAP_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int STALL_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rec_valid,
  input  logic [GAP_W-1:0]           rec_gap,
  input  logic [ADDR_W-1:0]          rec_addr,
  output logic                       rec_pop,
  output logic [ADDR_W-1:0]          look_addr,
  input  logic [$clog2(IPC+1)-1:0]   win_free,
  input  logic                       win_dup,
  input  logic                       l1_hit,
  input  logic                       mshr_ok,
  input  logic                       l2_hit,
  input  logic                       ctrl_ok,
  output logic [IPC-1:0]             add_vld,
  output logic [IPC-1:0]             add_rdy,
  output logic [IPC-1:0]             add_mem,
  output logic [ADDR_W-1:0]          add_addr,
  output logic                       mshr_req,
  output logic                       mem_req,
  output logic                       hitq_push,
  output logic                       mshr_retry,
  output logic                       ctrl_retry,
  output logic [STALL_W-1:0]         stall_cnt
);

  localparam int FREE_W = $clog2(IPC + 1);

  lookup_t           lk;
  logic              cur_valid;
  logic [GAP_W-1:0]  cur_gap;
  logic [ADDR_W-1:0] cur_addr;
  logic [IPC:0]      run;
  logic [GAP_W-1:0]  gap [IPC+1];
  logic [IPC-1:0]    mem_step;
  step_t             step [IPC];
  logic [IPC-1:0]    v_consume, v_mtry, v_mfail, v_cfail, v_issue, v_hitq;

  always_comb begin
    lk.dup     = win_dup;
    lk.l1      = l1_hit;
    lk.mshr_ok = mshr_ok;
    lk.l2      = l2_hit;
    lk.ctrl_ok = ctrl_ok;
    run[0]     = cur_valid & ~mshr_retry & ~ctrl_retry;
    gap[0]     = cur_gap;
  end

  for (genvar i = 0; i < IPC; i++) begin : g_slot
    issue_slot #(.GAP_W(GAP_W)) u_slot (
      .run_in    (run[i]),
      .slot_free (win_free > FREE_W'(i)),
      .gap_in    (gap[i]),
      .lk        (lk),
      .run_out   (run[i+1]),
      .gap_out   (gap[i+1]),
      .add_v     (add_vld[i]),
      .add_r     (add_rdy[i]),
      .add_m     (add_mem[i]),
      .mem_step  (mem_step[i]),
      .step      (step[i])
    );
    always_comb begin
      v_consume[i] = step[i].consume;
      v_mtry[i]    = step[i].mshr_try;
      v_mfail[i]   = step[i].mshr_fail;
      v_cfail[i]   = step[i].ctrl_fail;
      v_issue[i]   = step[i].issue;
      v_hitq[i]    = step[i].hitq;
    end
  end

  always_comb begin
    mshr_req  = |v_mtry;
    mem_req   = |v_issue;
    hitq_push = |v_hitq;
    look_addr = cur_addr;
    add_addr  = cur_addr;
  end

  issue_state #(.GAP_W(GAP_W), .ADDR_W(ADDR_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .consume    (|v_consume),
    .mshr_fail  (|v_mfail),
    .ctrl_fail  (|v_cfail),
    .mshr_ok    (mshr_ok),
    .ctrl_ok    (ctrl_ok),
    .gap_after  (gap[IPC]),
    .rec_valid  (rec_valid),
    .rec_gap    (rec_gap),
    .rec_addr   (rec_addr),
    .rec_pop    (rec_pop),
    .cur_valid  (cur_valid),
    .cur_gap    (cur_gap),
    .cur_addr   (cur_addr),
    .mshr_retry (mshr_retry),
    .ctrl_retry (ctrl_retry)
  );

  issue_stall_ctr #(.STALL_W(STALL_W), .FREE_W(FREE_W)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_free  (win_free),
    .stall_cnt (stall_cnt)
  );

  // R10: one memory step per cycle at most
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_step) && ($countones(add_mem) <= 1));

  // R2: used slots are contiguous from slot 0
  a_r2_contig: assert property (@(posedge clk) disable iff (!rst_n)
    ((add_vld + 1'b1) & add_vld) == '0);

  // R11: flags block every slot and request
  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mshr_retry || ctrl_retry) |-> (add_vld == '0 && !mshr_req && !mem_req && !hitq_push));

  // R8: a dispatch always carries a not-ready memory entry
  a_r8_pending_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (|(add_mem & ~add_rdy)));

  // R9: a refused dispatch raises the controller flag
  a_r9_ctrl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mshr_req && mshr_ok && !l2_hit && !ctrl_ok) |=> ctrl_retry);

endmodule

// File: tb/issue_stage_test.sv
module issue_stage_test;

  localparam int IPC = 4;
  localparam int GW  = 8;
  localparam int AW  = 16;
  localparam int SW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rec_valid;
  logic [GW-1:0] rec_gap;
  logic [AW-1:0] rec_addr;
  logic rec_pop;
  logic [AW-1:0] look_addr;
  logic [2:0] win_free;
  logic win_dup, l1_hit, mshr_ok, l2_hit, ctrl_ok;
  logic [IPC-1:0] add_vld, add_rdy, add_mem;
  logic [AW-1:0] add_addr;
  logic mshr_req, mem_req, hitq_push, mshr_retry, ctrl_retry;
  logic [SW-1:0] stall_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_stall = 0;

  always #5 clk = ~clk;

  issue_stage #(.IPC(IPC), .GAP_W(GW), .ADDR_W(AW), .STALL_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_gap(rec_gap),
    .rec_addr(rec_addr), .rec_pop(rec_pop), .look_addr(look_addr),
    .win_free(win_free), .win_dup(win_dup), .l1_hit(l1_hit), .mshr_ok(mshr_ok),
    .l2_hit(l2_hit), .ctrl_ok(ctrl_ok), .add_vld(add_vld), .add_rdy(add_rdy),
    .add_mem(add_mem), .add_addr(add_addr), .mshr_req(mshr_req),
    .mem_req(mem_req), .hitq_push(hitq_push), .mshr_retry(mshr_retry),
    .ctrl_retry(ctrl_retry), .stall_cnt(stall_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int free, input logic d, input logic l1,
                       input logic mo, input logic l2, input logic co);
    win_free = 3'(free);
    win_dup  = d;
    l1_hit   = l1;
    mshr_ok  = mo;
    l2_hit   = l2;
    ctrl_ok  = co;
  endtask

  // Clock edge; the bench counts full-window edges itself
  task automatic tick();
    if (win_free == 3'd0) exp_stall++;
    @(posedge clk);
    @(negedge clk);
  endtask

  // oc: 0 false miss, 1 L1 hit, 2 MSHR refuse, 3 L2 hit, 4 dispatch, 5 controller refuse
  task automatic run_case(input int g, input int f, input int oc, input int a);
    int k, adds, vm, rm, mm;
    bit ms, memadd;
    // load the record with a full window
    rec_valid = 1'b1;
    rec_gap   = GW'(g);
    rec_addr  = AW'(a);
    drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R12 rec_pop", int'(rec_pop), 1);
    tick();
    rec_valid = 1'b0;
    drive(f, oc == 0, oc == 1, oc >= 3, oc == 3, oc == 4);
    #1;
    k      = (g < f) ? g : f;
    ms     = (g < f);
    memadd = ms && (oc == 1 || oc == 4);
    adds   = k + (memadd ? 1 : 0);
    vm     = (1 << adds) - 1;
    rm     = ((1 << k) - 1) | ((ms && oc == 1) ? (1 << k) : 0);
    mm     = memadd ? (1 << k) : 0;
    chk("R2 R10 add_vld", int'(add_vld), vm);
    chk("R2 R5 R8 add_rdy", int'(add_rdy), rm);
    chk("R5 R8 add_mem", int'(add_mem), mm);
    chk("R4 R6 mshr_req", int'(mshr_req), int'(ms && oc >= 2));
    chk("R8 R9 mem_req", int'(mem_req), int'(ms && oc == 4));
    chk("R7 hitq_push", int'(hitq_push), int'(ms && oc == 3));
    chk("R12 rec_pop held", int'(rec_pop), 0);
    if (memadd) chk("R5 add_addr", int'(add_addr), a);
    tick();
    chk("R6 mshr_retry", int'(mshr_retry), int'(ms && oc == 2));
    chk("R9 ctrl_retry", int'(ctrl_retry), int'(ms && oc == 5));
    if (ms && (oc == 2 || oc == 5)) begin
      drive(IPC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      #1;
      chk("R11 blocked add_vld", int'(add_vld), 0);
      tick();
      chk("R11 flag held", int'(mshr_retry | ctrl_retry), 1);
      drive(IPC, 1'b1, 1'b0, oc == 2, 1'b0, oc == 5);
      #1;
      chk("R11 accept cycle idle", int'(add_vld) + int'(mshr_req) + int'(mem_req), 0);
      tick();
      chk("R11 flag cleared", int'(mshr_retry | ctrl_retry), 0);
    end
    // drain: finish the count, drop the read
    for (int c = 0; c < 3; c++) begin
      drive(IPC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      tick();
    end
    chk("R3 stall_cnt", int'(stall_cnt), exp_stall);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    rec_valid = 1'b0;
    rec_gap   = '0;
    rec_addr  = '0;
    drive(IPC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 add_vld", int'(add_vld), 0);
    chk("R1 requests", int'(mshr_req) + int'(mem_req) + int'(hitq_push), 0);
    chk("R1 retry flags", int'(mshr_retry) + int'(ctrl_retry), 0);
    chk("R1 stall_cnt", int'(stall_cnt), 0);
    chk("R1 rec_pop", int'(rec_pop), 0);
    tick();
    for (int oc = 0; oc < 6; oc++)
      for (int g = 0; g < 6; g++)
        for (int f = 0; f <= IPC; f++)
          run_case(g, f, oc, 16'h1000 + oc * 64 + g * 8 + f);
    // R12: a record loads in the cycle the held one is consumed
    rec_valid = 1'b1; rec_gap = 8'd0; rec_addr = 16'h0aa0;
    drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick();
    rec_gap = 8'd2; rec_addr = 16'h0bb0;
    drive(IPC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R12 pop on consume", int'(rec_pop), 1);
    chk("R5 L1 entry", int'(add_mem), 1);
    tick();
    rec_valid = 1'b0;
    drive(IPC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R12 new count first", int'(add_vld), 7);
    chk("R12 new addr", int'(add_addr), 16'h0bb0);
    tick();
    chk("R3 stall final", int'(stall_cnt), exp_stall);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule